// File: doc/BRIEF.md
# Multi-cycle instruction sequencer

This block is the control unit of a small byte-oriented processor. It pulls an opcode byte, then a mode byte that names how the operands are reached, then one or two operand bytes from a 256-byte memory. Each instruction is a short run of single-cycle states, and how many there are depends on the addressing form. The block holds the program counter, the instruction and mode bytes, the first-operand address register and two operand data registers. It also holds four general registers and the carry and zero flags. The arithmetic itself is done outside the block. The sequencer presents an operation code and two operand values to an external ALU and takes back a result and two flags in the same cycle.

Memory is read combinationally: the data for `mem_addr` must be valid within the same cycle. A write is a single-cycle `mem_we` pulse. Three request pulses control execution. Run starts continuous execution, stop pauses it at the next instruction boundary, and step executes exactly one instruction. A halt instruction or an illegal encoding parks the block until the asynchronous reset is applied.

Top module: `insn_seq`

## Requirements
- R1: After reset, `pc` is 0 and `running`, `halted`, `fault` and `mem_we` are all 0.
- R2: Opcode 0x00 does nothing and advances `pc` by one. Opcode 0xFF sets `halted`, leaves `pc` on the halt byte, never writes memory and ignores run and step until reset.
- R3: For opcodes 0x01 to 0x06 and 0x0B to 0x0D, the mode byte selects the operand pair. The codes are 0x00 register/register, 0x01 register/memory, 0x02 memory/register, 0x03 register/immediate, 0x05 memory/memory and 0x06 memory/immediate. Operand bytes follow the mode byte in operand order. A register byte selects a register with its low 2 bits. A memory byte is an address. An immediate byte is the value itself.
- R4: The result goes to the first operand. In a register form it goes to the selected register, and in a memory form it goes to the first operand's address with one single-cycle write.
- R5: Compare (0x0D) updates the flags but writes nothing back.
- R6: Move (0x01) stores the second operand unchanged and leaves the flags as they were.
- R7: Invert (0x07) takes one operand, either a register (mode 0x00) or memory (mode 0x01), and writes the inverted value back to it.
- R8: Jump (0x08) loads `pc` with a register value (mode 0x00), a memory byte (mode 0x01) or an immediate (mode 0x03).
- R9: Jump-if-zero (0x09) and jump-if-carry (0x0A) jump only when the zero or carry flag is set. Otherwise `pc` continues past the operand byte.
- R10: An undefined opcode, or a mode not listed for its opcode, sets `fault` and `halted`.
- R11: A step request while paused executes one instruction and then waits with `running` low.
- R12: A stop request clears `running` on the next cycle, lets the current instruction finish, and freezes `pc` until a new run request.
- R13: `alu_op` is the low nibble of the opcode, and `alu_a` and `alu_b` carry the first and second operand values. `alu_y` is the result for every operation except move. `alu_cf` and `alu_zf` are latched as the carry and zero flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Start continuous execution |
| step_req | input | 1 | Execute one instruction while paused |
| stop_req | input | 1 | Pause at the next instruction boundary |
| mem_addr | output | DW | Memory byte address |
| mem_rdata | input | DW | Memory read data, combinational from mem_addr |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| alu_op | output | 4 | Operation code to the ALU |
| alu_a | output | DW | First operand value |
| alu_b | output | DW | Second operand value |
| alu_y | input | DW | ALU result |
| alu_cf | input | 1 | ALU carry/borrow out |
| alu_zf | input | 1 | ALU zero indication |
| pc | output | DW | Program counter |
| running | output | 1 | Continuous execution active |
| halted | output | 1 | Parked by halt or fault |
| fault | output | 1 | Illegal opcode or mode seen |

## Verification
The bench builds the block with its defaults, a byte width of 8 and four general registers. The operand byte therefore addresses the whole 256-byte space, and a register byte uses its low two bits. The bench provides its own ALU and memory. With these defaults every addressing form of every operation can be driven, including both memory reads of a memory/memory form and the write back to the first operand address. Jump targets anywhere in memory, and the undefined opcode range 0x0E to 0xFE, can also be reached.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    OK_NONE,
    OK_REG,
    OK_MEM,
    OK_IMM
  } opnd_kind_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_MODE,
    ST_FETCH_A,
    ST_READ_A,
    ST_FETCH_B,
    ST_READ_B,
    ST_EXEC,
    ST_HALT
  } seq_state_t;

  typedef struct packed {
    logic       legal;
    opnd_kind_t src_a;
    opnd_kind_t src_b;
  } form_t;

  localparam logic [7:0] OP_NOP = 8'h00;
  localparam logic [7:0] OP_MOV = 8'h01;
  localparam logic [7:0] OP_NOT = 8'h07;
  localparam logic [7:0] OP_JMP = 8'h08;
  localparam logic [7:0] OP_JZ  = 8'h09;
  localparam logic [7:0] OP_JC  = 8'h0A;
  localparam logic [7:0] OP_CMP = 8'h0D;
  localparam logic [7:0] OP_HLT = 8'hFF;

  function automatic logic opc_known(input logic [7:0] c);
    return (c <= OP_CMP) || (c == OP_HLT);
  endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [7:0] mode,
  output form_t      form,
  output logic       is_jump,
  output logic       is_mov,
  output logic       is_cmp
);

  always_comb begin
    is_jump    = (opcode == OP_JMP) || (opcode == OP_JZ) || (opcode == OP_JC);
    is_mov     = (opcode == OP_MOV);
    is_cmp     = (opcode == OP_CMP);
    form.legal = 1'b1;
    form.src_a = OK_NONE;
    form.src_b = OK_NONE;
    if (is_jump) begin
      case (mode)
        8'h00:   form.src_a = OK_REG;
        8'h01:   form.src_a = OK_MEM;
        8'h03:   form.src_a = OK_IMM;
        default: form.legal = 1'b0;
      endcase
    end else if (opcode == OP_NOT) begin
      case (mode)
        8'h00:   form.src_a = OK_REG;
        8'h01:   form.src_a = OK_MEM;
        default: form.legal = 1'b0;
      endcase
    end else begin
      case (mode)
        8'h00: begin form.src_a = OK_REG; form.src_b = OK_REG; end
        8'h01: begin form.src_a = OK_REG; form.src_b = OK_MEM; end
        8'h02: begin form.src_a = OK_MEM; form.src_b = OK_REG; end
        8'h03: begin form.src_a = OK_REG; form.src_b = OK_IMM; end
        8'h05: begin form.src_a = OK_MEM; form.src_b = OK_MEM; end
        8'h06: begin form.src_a = OK_MEM; form.src_b = OK_IMM; end
        default: form.legal = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int DW    = 8,
  parameter int NREGS = 4,
  localparam int RSEL = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RSEL-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [RSEL-1:0] raddr,
  output logic [DW-1:0]   rdata
);

  logic [DW-1:0] bank [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic          wen;
    logic [DW-1:0] q;
    assign wen = we && (waddr == RSEL'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (wen) q <= wdata;
    end
    assign bank[g] = q;
  end

  assign rdata = bank[raddr];

endmodule

// File: rtl/seq_runctl.sv
module seq_runctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  logic stop_req,
  input  logic step_req,
  input  logic at_idle,
  input  logic halted,
  output logic go,
  output logic running
);

  logic running_q, running_d;

  always_comb begin
    running_d = running_q;
    if (halted || stop_req) running_d = 1'b0;
    else if (run_req)       running_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running_q <= 1'b0;
    else        running_q <= running_d;
  end

  assign go      = at_idle && !halted && !stop_req && (running_q || run_req || step_req);
  assign running = running_q;

endmodule

// File: rtl/insn_seq.sv
module insn_seq
  import seq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREGS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_req,
  input  logic          step_req,
  input  logic          stop_req,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [3:0]    alu_op,
  output logic [DW-1:0] alu_a,
  output logic [DW-1:0] alu_b,
  input  logic [DW-1:0] alu_y,
  input  logic          alu_cf,
  input  logic          alu_zf,
  output logic [DW-1:0] pc,
  output logic          running,
  output logic          halted,
  output logic          fault
);

  localparam int            RSEL = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [DW-1:0] ONE  = DW'(1);

  seq_state_t    state_q, state_d;
  logic [DW-1:0] pc_q, pc_d;
  logic [DW-1:0] op_q, op_d;
  logic [DW-1:0] mode_q, mode_d;
  logic [DW-1:0] ma_q, ma_d;
  logic [DW-1:0] dta_q, dta_d;
  logic [DW-1:0] dtb_q, dtb_d;
  logic          cf_q, cf_d, zf_q, zf_d, fault_q, fault_d;

  form_t         form;
  logic          is_jump, is_mov, is_cmp, single, take, go;
  logic [7:0]    mode_sel;
  logic [DW-1:0] result, rf_rdata;
  logic          rf_we;

  assign mode_sel = (state_q == ST_MODE) ? mem_rdata[7:0] : mode_q[7:0];

  seq_decode u_dec (
    .opcode  (op_q[7:0]),
    .mode    (mode_sel),
    .form    (form),
    .is_jump (is_jump),
    .is_mov  (is_mov),
    .is_cmp  (is_cmp)
  );

  seq_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (ma_q[RSEL-1:0]),
    .wdata (result),
    .raddr (mem_rdata[RSEL-1:0]),
    .rdata (rf_rdata)
  );

  seq_runctl u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_req  (run_req),
    .stop_req (stop_req),
    .step_req (step_req),
    .at_idle  (state_q == ST_IDLE),
    .halted   (halted),
    .go       (go),
    .running  (running)
  );

  assign single = (form.src_b == OK_NONE);
  assign result = is_mov ? dtb_q : alu_y;
  assign take   = (op_q[7:0] == OP_JMP) ||
                  ((op_q[7:0] == OP_JZ) && zf_q) ||
                  ((op_q[7:0] == OP_JC) && cf_q);

  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    op_d     = op_q;
    mode_d   = mode_q;
    ma_d     = ma_q;
    dta_d    = dta_q;
    dtb_d    = dtb_q;
    cf_d     = cf_q;
    zf_d     = zf_q;
    fault_d  = fault_q;
    mem_addr = pc_q;
    mem_we   = 1'b0;
    rf_we    = 1'b0;
    case (state_q)
      ST_IDLE: if (go) state_d = ST_OPC;
      ST_OPC: begin
        op_d = mem_rdata;
        if (mem_rdata[7:0] == OP_HLT) begin
          state_d = ST_HALT;
        end else if (!opc_known(mem_rdata[7:0])) begin
          fault_d = 1'b1;
          state_d = ST_HALT;
        end else begin
          pc_d    = pc_q + ONE;
          state_d = (mem_rdata[7:0] == OP_NOP) ? ST_IDLE : ST_MODE;
        end
      end
      ST_MODE: begin
        mode_d = mem_rdata;
        pc_d   = pc_q + ONE;
        if (!form.legal) begin
          fault_d = 1'b1;
          state_d = ST_HALT;
        end else begin
          state_d = ST_FETCH_A;
        end
      end
      ST_FETCH_A: begin
        ma_d = mem_rdata;
        pc_d = pc_q + ONE;
        case (form.src_a)
          OK_REG:  dta_d = rf_rdata;
          OK_IMM:  dta_d = mem_rdata;
          default: dta_d = dta_q;
        endcase
        if (form.src_a == OK_MEM) state_d = ST_READ_A;
        else                      state_d = single ? ST_EXEC : ST_FETCH_B;
      end
      ST_READ_A: begin
        mem_addr = ma_q;
        dta_d    = mem_rdata;
        state_d  = single ? ST_EXEC : ST_FETCH_B;
      end
      ST_FETCH_B: begin
        pc_d    = pc_q + ONE;
        dtb_d   = (form.src_b == OK_REG) ? rf_rdata : mem_rdata;
        state_d = (form.src_b == OK_MEM) ? ST_READ_B : ST_EXEC;
      end
      ST_READ_B: begin
        mem_addr = dtb_q;
        dtb_d    = mem_rdata;
        state_d  = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_IDLE;
        if (is_jump) begin
          if (take) pc_d = dta_q;
        end else begin
          if (!is_cmp) begin
            if (form.src_a == OK_REG) begin
              rf_we = 1'b1;
            end else begin
              mem_we   = 1'b1;
              mem_addr = ma_q;
            end
          end
          if (!is_mov) begin
            cf_d = alu_cf;
            zf_d = alu_zf;
          end
        end
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      op_q    <= '0;
      mode_q  <= '0;
      ma_q    <= '0;
      dta_q   <= '0;
      dtb_q   <= '0;
      cf_q    <= 1'b0;
      zf_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      op_q    <= op_d;
      mode_q  <= mode_d;
      ma_q    <= ma_d;
      dta_q   <= dta_d;
      dtb_q   <= dtb_d;
      cf_q    <= cf_d;
      zf_q    <= zf_d;
      fault_q <= fault_d;
    end
  end

  assign mem_wdata = result;
  assign alu_op    = op_q[3:0];
  assign alu_a     = dta_q;
  assign alu_b     = dtb_q;
  assign pc        = pc_q;
  assign halted    = (state_q == ST_HALT);
  assign fault     = fault_q;

endmodule

// File: rtl/insn_seq_chk.sv
module insn_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_req,
  input logic          running,
  input logic          halted,
  input logic          fault,
  input logic          mem_we,
  input logic [3:0]    alu_op,
  input logic [DW-1:0] pc
);

  a_r10_fault_parks: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> halted);

  a_r2_halt_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc)));

  a_r2_halt_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  a_r5_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (alu_op != 4'hD));

  a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  a_r12_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !running);

  a_r2_halt_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !running);

endmodule

bind insn_seq insn_seq_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stop_req (stop_req),
  .running  (running),
  .halted   (halted),
  .fault    (fault),
  .mem_we   (mem_we),
  .alu_op   (alu_op),
  .pc       (pc)
);

// File: tb/insn_seq_bench.sv
module insn_seq_bench;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n, run_req, step_req, stop_req;
  logic [DW-1:0] mem_addr, mem_rdata, mem_wdata, alu_a, alu_b, alu_y, pc;
  logic          mem_we, alu_cf, alu_zf, running, halted, fault;
  logic [3:0]    alu_op;
  logic [7:0]    mem [256];
  logic [8:0]    wide;
  int            n_chk = 0;
  int            n_bad = 0;
  logic [7:0]    v_op, v_md, v_a, v_b, v_res, e80, ef0, held_pc;
  bit            ok;

  always #10 clk = ~clk;

  insn_seq u_insn_seq (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .step_req(step_req), .stop_req(stop_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_y(alu_y), .alu_cf(alu_cf),
    .alu_zf(alu_zf), .pc(pc), .running(running), .halted(halted), .fault(fault)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  // Bench ALU: carry out for add, borrow for subtract and compare.
  always_comb begin
    case (alu_op)
      4'h2:       wide = {1'b0, alu_a} + {1'b0, alu_b};
      4'h3, 4'hD: wide = {1'b0, alu_a} - {1'b0, alu_b};
      4'h4:       wide = {1'b0, alu_a & alu_b};
      4'h5:       wide = {1'b0, alu_a | alu_b};
      4'h6:       wide = {1'b0, alu_a ^ alu_b};
      4'h7:       wide = {1'b0, ~alu_a};
      4'hB:       wide = {1'b0, alu_a << alu_b[2:0]};
      4'hC:       wide = {1'b0, alu_a >> alu_b[2:0]};
      default:    wide = {1'b0, alu_b};
    endcase
    alu_y  = wide[7:0];
    alu_cf = wide[8];
    alu_zf = (wide[7:0] == 8'h00);
  end

  // {opcode, mode, first value, second value}
  localparam logic [31:0] VEC [16] = '{
    32'h02_00_13_22, 32'h02_06_F0_20, 32'h03_01_50_08, 32'h03_05_05_07,
    32'h04_02_F3_3C, 32'h05_03_81_14, 32'h06_05_AA_FF, 32'h0B_03_11_03,
    32'h0C_06_80_04, 32'h0D_00_10_10, 32'h0D_05_22_11, 32'h01_01_00_9C,
    32'h01_06_33_47, 32'h01_02_12_34, 32'h07_00_5A_00, 32'h07_01_0F_00
  };

  function automatic logic [7:0] expect_res(input logic [7:0] op, a, b);
    case (op)
      8'h01: return b;
      8'h02: return a + b;
      8'h03: return a - b;
      8'h04: return a & b;
      8'h05: return a | b;
      8'h06: return a ^ b;
      8'h07: return ~a;
      8'h0B: return a << b[2:0];
      8'h0C: return a >> b[2:0];
      default: return a;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst_n    = 1'b0;
    run_req  = 1'b0;
    step_req = 1'b0;
    stop_req = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input int addr, input logic [7:0] val);
    mem[addr] <= val;
  endtask

  task automatic put4(input int addr, input logic [7:0] b0, b1, b2, b3);
    put(addr, b0); put(addr + 1, b1); put(addr + 2, b2); put(addr + 3, b3);
  endtask

  task automatic pulse_run();
    run_req = 1'b1; @(negedge clk); run_req = 1'b0;
  endtask

  task automatic pulse_step();
    step_req = 1'b1; @(negedge clk); step_req = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic run_to_halt(output bit done);
    pulse_run();
    done = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (halted) begin done = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R11: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    hold_reset();
    release_reset();
    chk("R1 pc", pc, 0);
    chk("R1 running", running, 0);
    chk("R1 halted", halted, 0);
    chk("R1 fault", fault, 0);
    chk("R1 mem_we", mem_we, 0);

    // Vector walk: R3 R4 R5 R6 R7 R13
    for (int v = 0; v < 16; v++) begin
      {v_op, v_md, v_a, v_b} = VEC[v];
      hold_reset();
      put(8'h80, v_a);
      put(8'h81, v_b);
      put4(0, 8'h01, 8'h03, 8'h00, v_a);
      put4(4, 8'h01, 8'h03, 8'h01, v_b);
      put(8, v_op);
      put(9, v_md);
      if (v_op == 8'h07) begin
        put(10, (v_md == 8'h00) ? 8'h00 : 8'h80);
        put4(11, 8'h01, 8'h02, 8'hF0, 8'h00);
        put(15, 8'hFF);
      end else begin
        case (v_md)
          8'h00: begin put(10, 8'h00); put(11, 8'h01); end
          8'h01: begin put(10, 8'h00); put(11, 8'h81); end
          8'h02: begin put(10, 8'h80); put(11, 8'h01); end
          8'h03: begin put(10, 8'h00); put(11, v_b);   end
          8'h05: begin put(10, 8'h80); put(11, 8'h81); end
          default: begin put(10, 8'h80); put(11, v_b); end
        endcase
        put4(12, 8'h01, 8'h02, 8'hF0, 8'h00);
        put(16, 8'hFF);
      end
      release_reset();
      run_to_halt(ok);
      v_res = expect_res(v_op, v_a, v_b);
      e80 = v_a;
      ef0 = v_a;
      if (v_op != 8'h0D) begin
        if ((v_op == 8'h07) ? (v_md == 8'h01) : (v_md == 8'h02 || v_md == 8'h05 || v_md == 8'h06))
          e80 = v_res;
        else
          ef0 = v_res;
      end
      chk("R3 R4 R13 halted cleanly", {ok, fault}, {1'b1, 1'b0});
      chk("R4 R5 R6 R7 first-operand memory", mem[8'h80], e80);
      chk("R4 R5 R6 R7 register via store", mem[8'hF0], ef0);
    end

    // R2 no-ops then halt; run ignored after halt
    hold_reset();
    put(3, 8'hFF);
    release_reset();
    run_to_halt(ok);
    chk("R2 halt pc", pc, 3);
    chk("R2 no write by no-op", mem[0], 0);
    pulse_run();
    repeat (10) @(negedge clk);
    chk("R2 halt holds after run", {halted, running, pc}, {2'b10, 8'h03});

    // R9 R5 R6 jump-if-zero taken: compare sets zero, move keeps it
    hold_reset();
    put4(0, 8'h01, 8'h03, 8'h00, 8'h03);
    put4(4, 8'h0D, 8'h03, 8'h00, 8'h03);
    put4(8, 8'h01, 8'h03, 8'h01, 8'h09);
    put(12, 8'h09); put(13, 8'h03); put(14, 8'h40); put(15, 8'hFF);
    put(8'h40, 8'hFF);
    release_reset();
    run_to_halt(ok);
    chk("R9 R5 R6 jz taken", pc, 8'h40);

    // R9 jump-if-zero not taken
    hold_reset();
    put4(0, 8'h01, 8'h03, 8'h00, 8'h03);
    put4(4, 8'h0D, 8'h03, 8'h00, 8'h02);
    put4(8, 8'h01, 8'h03, 8'h01, 8'h09);
    put(12, 8'h09); put(13, 8'h03); put(14, 8'h40); put(15, 8'hFF);
    put(8'h40, 8'hFF);
    release_reset();
    run_to_halt(ok);
    chk("R9 jz not taken", pc, 8'h0F);

    // R9 jump-if-carry taken (3 - 5 borrows) and not taken (3 - 1)
    for (int t = 0; t < 2; t++) begin
      hold_reset();
      put4(0, 8'h01, 8'h03, 8'h00, 8'h03);
      put4(4, 8'h03, 8'h03, 8'h00, (t == 0) ? 8'h05 : 8'h01);
      put(8, 8'h0A); put(9, 8'h03); put(10, 8'h50); put(11, 8'hFF);
      put(8'h50, 8'hFF);
      release_reset();
      run_to_halt(ok);
      chk("R9 jc", pc, (t == 0) ? 8'h50 : 8'h0B);
    end

    // R8 jump through register and through memory
    hold_reset();
    put4(0, 8'h01, 8'h03, 8'h02, 8'h60);
    put(4, 8'h08); put(5, 8'h00); put(6, 8'h02); put(7, 8'hFF);
    put(8'h60, 8'hFF);
    release_reset();
    run_to_halt(ok);
    chk("R8 jump register", pc, 8'h60);
    hold_reset();
    put(0, 8'h08); put(1, 8'h01); put(2, 8'h90); put(3, 8'hFF);
    put(8'h90, 8'h70); put(8'h70, 8'hFF);
    release_reset();
    run_to_halt(ok);
    chk("R8 jump memory", pc, 8'h70);

    // R10 undefined opcode, bad invert mode, bad jump mode
    hold_reset();
    put(0, 8'h0E);
    release_reset();
    run_to_halt(ok);
    chk("R10 bad opcode", {ok, fault}, 2'b11);
    hold_reset();
    put(0, 8'h07); put(1, 8'h02);
    release_reset();
    run_to_halt(ok);
    chk("R10 bad invert mode", {ok, fault}, 2'b11);
    hold_reset();
    put(0, 8'h08); put(1, 8'h02);
    release_reset();
    run_to_halt(ok);
    chk("R10 bad jump mode", {ok, fault}, 2'b11);

    // R11 single step
    hold_reset();
    put4(0, 8'h01, 8'h03, 8'h00, 8'h05);
    put4(4, 8'h01, 8'h02, 8'hF0, 8'h00);
    put(8, 8'hFF);
    release_reset();
    pulse_step();
    repeat (20) @(negedge clk);
    chk("R11 first step pc", {running, halted, pc}, {2'b00, 8'h04});
    pulse_step();
    repeat (20) @(negedge clk);
    chk("R11 second step pc", {running, pc}, {1'b0, 8'h08});
    chk("R11 second step write", mem[8'hF0], 8'h05);

    // R12 stop and resume on a no-op stream
    hold_reset();
    release_reset();
    pulse_run();
    repeat (15) @(negedge clk);
    pulse_stop();
    repeat (4) @(negedge clk);
    held_pc = pc;
    repeat (20) @(negedge clk);
    chk("R12 stopped pc frozen", {running, pc}, {1'b0, held_pc});
    pulse_run();
    repeat (10) @(negedge clk);
    chk("R12 resumed", {running, (pc != held_pc)}, 2'b11);

    summary();
    $finish;
  end

endmodule